// File: doc/BRIEF.md
# PHY Control-Register Port Write Sequencer

This block performs one register write into a PHY's internal control-register port. That port is reached through a single command word and a single status word. A host places a 16-bit register address and a 16-bit value on the inputs and pulses `start`. The sequencer latches both operands and then runs three request/acknowledge handshakes in a fixed order: load the address, load the value, then commit the write.

Each handshake is a full four-phase exchange. The sequencer raises a one-hot command bit next to a shared 16-bit field and waits for the PHY to raise its acknowledge. It then drops the command bit while keeping the field, and waits for the acknowledge to fall. Each of these waits is bounded. If either wait runs too long, the whole write is abandoned and an error pulse is issued. A completed write produces a done pulse and keeps the 16-bit value that the PHY reported on its data-out field while acknowledging the commit.

The polling interval is a parameter counted in clock cycles, `POLL_CYCLES`. Its default is one microsecond at `CLK_HZ`. `WAIT_LIMIT` sets how many intervals one wait may last, so a single wait is allowed `POLL_CYCLES*WAIT_LIMIT` cycles.

Top module: `phy_cr_write_seq`

## Requirements
- R1: A synchronous active-high reset, whether applied at power-up or in the middle of a write, returns the block to idle with `cmdWord` all zero and `busy`, `done` and `timeoutErr` low.
- R2: In `cmdWord`, bits [17:2] carry the 16-bit field. Bit 0 requests address capture, bit 1 requests data capture and bit 19 requests the commit. At most one of these three bits is set at any time, and bit 18 (read) is never set.
- R3: Within each handshake the command bit stays set until the acknowledge (`statusWord[0]`) is seen high. The bit is then cleared while the field holds its value, and the next step waits until the acknowledge is seen low.
- R4: The handshakes run in this order: address capture with the address on the field, then data capture with the value on the field, then commit with the value still on the field.
- R5: Immediately before each capture handshake, the field is driven for exactly one cycle with no command bit set. The commit has no such cycle.
- R6: Each wait is allowed `POLL_CYCLES*WAIT_LIMIT` cycles, counted from the cycle in which its drive word first appears. An acknowledge first seen in the last allowed cycle is accepted. If none is seen by then, the cycle after the last allowed one shows `timeoutErr` high, `busy` low and `cmdWord` zero.
- R7: After a timeout in any wait, no later command bit of that write is issued.
- R8: A `start` pulse received while `busy` is high is ignored. The write in progress keeps its own address and value.
- R9: `done` and `timeoutErr` are single-cycle pulses that never occur together. `cmdWord` is zero whenever `busy` is low.
- R10: `phyDataOut` takes `statusWord[16:1]` at the moment the commit's acknowledge is seen high, and keeps that value until the next commit acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a write when the block is idle |
| addrIn | input | 16 | Register address, sampled on start |
| dataIn | input | 16 | Register value, sampled on start |
| statusWord | input | 17 | PHY status: bit 0 acknowledge, bits [16:1] data-out |
| cmdWord | output | 20 | PHY command: bits [17:2] field, bits 0/1/19 command strobes |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when a write completes |
| timeoutErr | output | 1 | One-cycle pulse when a wait exceeds its limit |
| phyDataOut | output | 16 | Data-out value captured at the commit acknowledge |

## Verification
The hardest situation to reach from the ports is the timeout boundary. That is an acknowledge that arrives in exactly the last allowed cycle of a wait, or one cycle after it. A normal PHY model always answers quickly, so it never comes near the limit. The bench's PHY responder therefore has a programmable reply delay, set both to the last allowed cycle and to one cycle past it. The responder can also refuse to raise the acknowledge for a chosen command bit, or refuse to release it afterwards. This drives a timeout in both the rising wait and the falling wait of different phases, and shows that no later phase is issued.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

  localparam int FIELD_W   = 16;
  localparam int FIELD_LSB = 2;
  localparam int CMD_W     = 20;
  localparam int STS_W     = 17;
  localparam int ACK_POS   = 0;
  localparam int OUT_LSB   = 1;
  localparam int READ_POS  = 18;
  localparam int NUM_CMD   = 3;

  // command strobe positions: index 0 address capture, 1 data capture, 2 commit
  localparam int CMD_POS [NUM_CMD] = '{0, 1, 19};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_ADDR,
    ST_ADDR_SET,
    ST_ADDR_CLR,
    ST_PRE_DATA,
    ST_DATA_SET,
    ST_DATA_CLR,
    ST_WR_SET,
    ST_WR_CLR
  } seqState_t;

  typedef struct packed {
    logic               capture;
    logic               fieldData;
    logic [NUM_CMD-1:0] cmdSel;
    logic               driveOn;
    logic               waitRun;
    logic               waitRestart;
    logic               grabOut;
  } seqStrobe_t;

endpackage

// File: rtl/phycr_datapath.sv
module phycr_datapath
  import phycr_pkg::*;
#(
  parameter int POLL_CYCLES = 50,
  parameter int WAIT_LIMIT  = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobe_t          strobe,
  input  logic [FIELD_W-1:0]  addrIn,
  input  logic [FIELD_W-1:0]  dataIn,
  input  logic [STS_W-1:0]    statusWord,
  output logic [CMD_W-1:0]    cmdWord,
  output logic                ackNow,
  output logic                timeoutHit,
  output logic [FIELD_W-1:0]  phyDataOut
);

  localparam int POLL_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int INT_W  = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
  localparam logic [INT_W-1:0] INT_LAST = INT_W'(WAIT_LIMIT - 1);

  logic [FIELD_W-1:0] addrQ;
  logic [FIELD_W-1:0] dataQ;
  logic [FIELD_W-1:0] outQ;
  logic [INT_W-1:0]   intvCnt;
  logic               pollWrap;
  logic               cntClear;

  assign cntClear = !strobe.waitRun || strobe.waitRestart;
  assign ackNow   = statusWord[ACK_POS];

  // operand and data-out capture
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      dataQ <= '0;
      outQ  <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ <= addrIn;
        dataQ <= dataIn;
      end
      if (strobe.grabOut) begin
        outQ <= statusWord[OUT_LSB +: FIELD_W];
      end
    end
  end

  // polling interval divider; a single-cycle interval needs no counter
  generate
    if (POLL_CYCLES == 1) begin : g_noPoll
      assign pollWrap = 1'b1;
    end else begin : g_poll
      localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_CYCLES - 1);
      logic [POLL_W-1:0] pollCnt;
      always_ff @(posedge clk) begin
        if (rst || cntClear) begin
          pollCnt <= '0;
        end else if (pollCnt == POLL_LAST) begin
          pollCnt <= '0;
        end else begin
          pollCnt <= pollCnt + 1'b1;
        end
      end
      assign pollWrap = (pollCnt == POLL_LAST);
    end
  endgenerate

  // count of elapsed polling intervals in the current wait
  always_ff @(posedge clk) begin
    if (rst || cntClear) begin
      intvCnt <= '0;
    end else if (pollWrap && intvCnt != INT_LAST) begin
      intvCnt <= intvCnt + 1'b1;
    end
  end

  assign timeoutHit = strobe.waitRun && pollWrap && (intvCnt == INT_LAST);

  // drive word assembly
  always_comb begin
    cmdWord = '0;
    if (strobe.driveOn) begin
      cmdWord[FIELD_LSB +: FIELD_W] = strobe.fieldData ? dataQ : addrQ;
      for (int i = 0; i < NUM_CMD; i++) begin
        if (strobe.cmdSel[i]) cmdWord[CMD_POS[i]] = 1'b1;
      end
    end
  end

  assign phyDataOut = outQ;

  // R2: one strobe at a time, read never driven
  assert_cmd_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmdWord[CMD_POS[2]], cmdWord[CMD_POS[1]], cmdWord[CMD_POS[0]]}) && !cmdWord[READ_POS]);

  // R8: latched operands do not move while a write is being driven
  assert_operands_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.driveOn && $past(strobe.driveOn)) |-> ($stable(addrQ) && $stable(dataQ)));

endmodule

// File: rtl/phycr_ctrl.sv
module phycr_ctrl
  import phycr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ackNow,
  input  logic       timeoutHit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       timeoutErr
);

  seqState_t state;
  seqState_t stateNext;
  logic      finishOk;
  logic      failHit;
  logic      setPhase;
  logic      ackPending;

  always_comb begin
    stateNext = state;
    finishOk  = 1'b0;
    failHit   = 1'b0;
    case (state)
      ST_IDLE:     if (start) stateNext = ST_PRE_ADDR;
      ST_PRE_ADDR: stateNext = ST_ADDR_SET;
      ST_ADDR_SET: begin
        if (ackNow) stateNext = ST_ADDR_CLR;
        else if (timeoutHit) begin stateNext = ST_IDLE; failHit = 1'b1; end
      end
      ST_ADDR_CLR: begin
        if (!ackNow) stateNext = ST_PRE_DATA;
        else if (timeoutHit) begin stateNext = ST_IDLE; failHit = 1'b1; end
      end
      ST_PRE_DATA: stateNext = ST_DATA_SET;
      ST_DATA_SET: begin
        if (ackNow) stateNext = ST_DATA_CLR;
        else if (timeoutHit) begin stateNext = ST_IDLE; failHit = 1'b1; end
      end
      ST_DATA_CLR: begin
        if (!ackNow) stateNext = ST_WR_SET;
        else if (timeoutHit) begin stateNext = ST_IDLE; failHit = 1'b1; end
      end
      ST_WR_SET: begin
        if (ackNow) stateNext = ST_WR_CLR;
        else if (timeoutHit) begin stateNext = ST_IDLE; failHit = 1'b1; end
      end
      ST_WR_CLR: begin
        if (!ackNow) begin stateNext = ST_IDLE; finishOk = 1'b1; end
        else if (timeoutHit) begin stateNext = ST_IDLE; failHit = 1'b1; end
      end
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state      <= stateNext;
      done       <= finishOk;
      timeoutErr <= failHit;
    end
  end

  always_comb begin
    strobe.capture     = (state == ST_IDLE) && start;
    strobe.fieldData   = state inside {ST_PRE_DATA, ST_DATA_SET, ST_DATA_CLR, ST_WR_SET, ST_WR_CLR};
    strobe.cmdSel      = {state == ST_WR_SET, state == ST_DATA_SET, state == ST_ADDR_SET};
    strobe.driveOn     = (state != ST_IDLE);
    strobe.waitRun     = state inside {ST_ADDR_SET, ST_ADDR_CLR, ST_DATA_SET, ST_DATA_CLR,
                                       ST_WR_SET, ST_WR_CLR};
    strobe.waitRestart = (stateNext != state);
    strobe.grabOut     = (state == ST_WR_SET) && ackNow;
  end

  assign busy       = (state != ST_IDLE);
  assign setPhase   = |strobe.cmdSel;
  assign ackPending = setPhase ? !ackNow : ackNow;

  // R6: an unmet wait at its limit ends in an error pulse and idle
  assert_timeout_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.waitRun && ackPending && timeoutHit) |=> (timeoutErr && !busy));

  // R9: pulses are one cycle wide and exclusive
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    timeoutErr |=> !timeoutErr);
  assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && timeoutErr));

  // R7: an ended write leaves the block idle
  assert_end_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (done || timeoutErr) |-> !busy);

endmodule

// File: rtl/phy_cr_write_seq.sv
module phy_cr_write_seq
  import phycr_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int POLL_CYCLES = CLK_HZ / 1_000_000,
  parameter int WAIT_LIMIT  = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [FIELD_W-1:0]  addrIn,
  input  logic [FIELD_W-1:0]  dataIn,
  input  logic [STS_W-1:0]    statusWord,
  output logic [CMD_W-1:0]    cmdWord,
  output logic                busy,
  output logic                done,
  output logic                timeoutErr,
  output logic [FIELD_W-1:0]  phyDataOut
);

  seqStrobe_t strobe;
  logic       ackNow;
  logic       timeoutHit;
  logic       cmdActive;

  phycr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ackNow     (ackNow),
    .timeoutHit (timeoutHit),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  phycr_datapath #(
    .POLL_CYCLES (POLL_CYCLES),
    .WAIT_LIMIT  (WAIT_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .addrIn     (addrIn),
    .dataIn     (dataIn),
    .statusWord (statusWord),
    .cmdWord    (cmdWord),
    .ackNow     (ackNow),
    .timeoutHit (timeoutHit),
    .phyDataOut (phyDataOut)
  );

  assign cmdActive = cmdWord[CMD_POS[0]] | cmdWord[CMD_POS[1]] | cmdWord[CMD_POS[2]];

  // R9: nothing driven toward the PHY while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cmdWord == '0));

  // R3: a strobe is withdrawn mid-write only after the acknowledge was seen
  assert_clear_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $fell(cmdActive)) |-> $past(statusWord[ACK_POS]));

endmodule

// File: tb/phy_cr_write_seq_tb.sv
module phy_cr_write_seq_tb;

  localparam int POLL   = 4;
  localparam int LIMIT  = 5;
  localparam int WINDOW = POLL * LIMIT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [16:0] statusWord;
  logic [19:0] cmdWord;
  logic        busy, done, timeoutErr;
  logic [15:0] phyDataOut;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  phy_cr_write_seq #(.POLL_CYCLES(POLL), .WAIT_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .addrIn(addrIn), .dataIn(dataIn),
    .statusWord(statusWord), .cmdWord(cmdWord), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .phyDataOut(phyDataOut)
  );

  // ---------------- PHY responder model ----------------
  logic        ackR = 1'b0;
  logic [15:0] respOut = '0;
  int          respDelay = 0;
  int          refuseBit = -1;
  int          holdBit = -1;
  int          lastBit = -1;
  int          rcnt = 0;
  int          logN = 0;
  int          logBit [8];
  logic [15:0] logField [8];
  logic [19:0] logPrev [8];
  logic [19:0] prevCmd = '0;
  bit          sawRead = 0;

  assign statusWord = {respOut, ackR};

  function automatic int activeBit(logic [19:0] w);
    if (w[0]) return 0;
    if (w[1]) return 1;
    if (w[19]) return 19;
    return -1;
  endfunction

  always @(negedge clk) begin
    int b;
    if (rst) begin
      ackR = 1'b0;
      rcnt = 0;
      prevCmd = '0;
    end else begin
      b = activeBit(cmdWord);
      if (cmdWord[18]) sawRead = 1;
      if (b >= 0 && activeBit(prevCmd) != b && logN < 8) begin
        logBit[logN]   = b;
        logField[logN] = cmdWord[17:2];
        logPrev[logN]  = prevCmd;
        logN++;
      end
      if (b >= 0 && !ackR) begin
        lastBit = b;
        if (b != refuseBit) begin
          if (rcnt >= respDelay) begin ackR = 1'b1; rcnt = 0; end
          else rcnt++;
        end
      end else if (b < 0 && ackR) begin
        if (lastBit != holdBit) begin
          if (rcnt >= respDelay) begin ackR = 1'b0; rcnt = 0; end
          else rcnt++;
        end
      end else begin
        rcnt = 0;
      end
      prevCmd = cmdWord;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    logN = 0;
    sawRead = 0;
  endtask

  task automatic launch(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addrIn = a;
    dataIn = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for the end of a write; outcome 1 done, 2 error, 0 none
  task automatic waitEnd(output int outcome);
    int n;
    n = 0;
    outcome = 0;
    while (!done && !timeoutErr && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (done) outcome = 1;
    else if (timeoutErr) outcome = 2;
  endtask

  task automatic checkGoodWrite(input logic [15:0] a, input logic [15:0] d,
                                input logic [15:0] ro, input string tag);
    int oc;
    waitEnd(oc);
    check(oc == 1, "R4", {tag, " write completes"}, oc, 1);
    check(cmdWord == 20'h0 && !busy, "R9", {tag, " idle drive word at done"}, cmdWord, 0);
    check(logN == 3, "R4", {tag, " three handshakes"}, logN, 3);
    if (logN == 3) begin
      check(logBit[0] == 0 && logField[0] == a, "R4", {tag, " phase 1 address capture"},
            {logBit[0][7:0], logField[0]}, {8'd0, a});
      check(logBit[1] == 1 && logField[1] == d, "R4", {tag, " phase 2 data capture"},
            {logBit[1][7:0], logField[1]}, {8'd1, d});
      check(logBit[2] == 19 && logField[2] == d, "R4", {tag, " phase 3 commit"},
            {logBit[2][7:0], logField[2]}, {8'd19, d});
      check(logPrev[0] == {2'b00, a, 2'b00}, "R5", {tag, " pre-cycle before address"},
            logPrev[0], {2'b00, a, 2'b00});
      check(logPrev[1] == {2'b00, d, 2'b00}, "R5", {tag, " pre-cycle before data"},
            logPrev[1], {2'b00, d, 2'b00});
      check(logPrev[2] == {2'b00, d, 2'b00}, "R3", {tag, " field held after data strobe clear"},
            logPrev[2], {2'b00, d, 2'b00});
    end
    check(!sawRead, "R2", {tag, " read bit never driven"}, sawRead, 0);
    check(phyDataOut == ro, "R10", {tag, " data-out captured"}, phyDataOut, ro);
    @(negedge clk);
    check(!done, "R9", {tag, " done is one cycle"}, done, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(cmdWord == 0 && !busy && !done && !timeoutErr, "R1", "state after reset",
          {cmdWord, busy, done, timeoutErr}, 0);
  endtask

  task automatic t_basic(input logic [15:0] a, input logic [15:0] d, input int dly,
                         input logic [15:0] ro, input string tag);
    respDelay = dly;
    respOut = ro;
    clearLog();
    launch(a, d);
    checkGoodWrite(a, d, ro, tag);
  endtask

  task automatic t_busy_start();
    respDelay = 3;
    respOut = 16'h0F0F;
    clearLog();
    launch(16'h0015, 16'hA000);
    repeat (4) @(negedge clk);
    addrIn = 16'h7777;
    dataIn = 16'h8888;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkGoodWrite(16'h0015, 16'hA000, 16'h0F0F, "R8 busy start");
  endtask

  task automatic t_hold_dataout();
    respOut = 16'hDEAD;
    repeat (3) @(negedge clk);
    check(phyDataOut == 16'h0F0F, "R10", "data-out held while idle", phyDataOut, 16'h0F0F);
  endtask

  task automatic t_timeout_set();
    int k;
    int oc;
    respDelay = 0;
    refuseBit = 0;
    clearLog();
    launch(16'h1234, 16'h5678);
    k = 0;
    while (!cmdWord[0] && k < 100) begin @(negedge clk); k++; end
    k = 0;
    while (!timeoutErr && k < 200) begin @(negedge clk); k++; end
    check(k == WINDOW, "R6", "address wait timeout cycle", k, WINDOW);
    check(!busy && cmdWord == 0, "R6", "idle at timeout", {busy, cmdWord}, 0);
    @(negedge clk);
    check(!timeoutErr, "R9", "error is one cycle", timeoutErr, 0);
    repeat (10) @(negedge clk);
    check(logN == 1, "R7", "no phase after address timeout", logN, 1);
    refuseBit = -1;
    oc = 0;
  endtask

  task automatic t_timeout_clear();
    int oc;
    respDelay = 0;
    holdBit = 1;
    clearLog();
    launch(16'h00AA, 16'h00BB);
    waitEnd(oc);
    check(oc == 2, "R6", "release wait timeout", oc, 2);
    repeat (10) @(negedge clk);
    check(logN == 2 && logBit[1] == 1, "R7", "commit not issued after data timeout", logN, 2);
    check(cmdWord == 0, "R7", "drive word stays clear", cmdWord, 0);
    holdBit = -1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_edge_late();
    int oc;
    respDelay = WINDOW;
    clearLog();
    launch(16'h0042, 16'h4242);
    waitEnd(oc);
    check(oc == 2, "R6", "acknowledge one cycle past limit rejected", oc, 2);
    repeat (10) @(negedge clk);
    check(logN == 1, "R7", "late acknowledge stops write", logN, 1);
  endtask

  task automatic t_mid_reset();
    respDelay = 2;
    clearLog();
    launch(16'h3333, 16'h4444);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(cmdWord == 0 && !busy && !done && !timeoutErr, "R1", "reset mid-write",
          {cmdWord, busy}, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic(16'h0015, 16'hA5A5, 0, 16'h1111, "R4 fast");
    t_basic(16'hFFFF, 16'h0000, 3, 16'h2222, "R3 slow");
    t_basic(16'h1010, 16'h5A5A, WINDOW - 1, 16'h3333, "R6 last-cycle acknowledge");
    t_busy_start();
    t_hold_dataout();
    t_timeout_set();
    t_timeout_clear();
    t_edge_late();
    t_mid_reset();
    t_basic(16'h00C3, 16'h8001, 1, 16'h4444, "R1 after reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule